// File: doc/BRIEF.md
# Receive Elastic Clock-Crossing Buffer

This block takes received link data that arrives on the transceiver's recovered clock and hands it to the core clock domain. The transceiver side delivers narrow words of 8, 16 or 32 bits, chosen by a parameter. The block gathers them into 32-bit entries and writes those entries into a dual-clock FIFO. The FIFO depth is set as a power of two through a log2 parameter. On the core side, a consumer pulls one 32-bit word per request once the buffer is running.

The buffer adds a delay that varies with link conditions. The core-side fill level is reported in entries, so that this delay can be measured. The core side raises a resynchronize request, for example after a change of line rate. The request clears both pointers, throws away any partly packed entry and clears the sticky error flags. Reading then waits until the buffer has filled to half its depth, which centres it against jitter and wander.

The core-side controller is a state machine with four states:
- **FILL** waits for half depth. It goes to RUN once the fill level reaches DEPTH/2, and to FLUSH on resync.
- **RUN** serves reads. It goes to FLUSH on resync.
- **FLUSH** holds the pointer-clear request towards the write side. It goes to DRAIN when the write side acknowledges.
- **DRAIN** waits for that acknowledge to drop. It then returns to FILL.

Reset enters FILL.

Top module: `rx_elastic_buf`

## Requirements
- R1: With an 8-bit input, four accepted input bytes form one entry, and the first byte received occupies bits [7:0], up through the fourth byte in bits [31:24].
- R2: With a 16-bit input, two accepted halfwords form one entry, and the first received occupies bits [15:0].
- R3: With a 32-bit input, each accepted word becomes one entry unchanged, and entries leave the buffer in the order they were written.
- R4: After reset or a resync, `running` stays 0 and `rd_en` produces no output until `fill_level` has reached half the depth. Then `running` goes to 1.
- R5: While running, `rd_en` with a non-empty buffer gives `out_valid`=1 one core clock later, with the oldest stored entry on `out_data`.
- R6: `fill_level` gives the number of stored entries as seen in the core domain, and it never exceeds the depth.
- R7: An entry completed while the buffer is full is dropped, so the earliest DEPTH entries are kept. `ovf_flag` then becomes 1 and stays 1 until a resync.
- R8: `rd_en` while running with an empty buffer produces no `out_valid`. It sets `unf_flag`, which stays 1 until a resync.
- R9: A one-cycle `resync` pulse clears both pointers, a partly packed entry and both flags. It makes `running` 0 on the next cycle and sends the block back to FILL. Entries written afterwards are the only ones delivered.
- R10: After reset, `out_valid`, `running`, `ovf_flag`, `unf_flag` and `fill_level` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered transceiver clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| rx_valid | input | 1 | Input word valid |
| rx_data | input | IN_W | Input word (8, 16 or 32 bits) |
| rd_clk | input | 1 | Core clock |
| rd_rst_n | input | 1 | Active-low reset, core domain |
| resync | input | 1 | Pulse: clear pointers and realign |
| rd_en | input | 1 | Request one entry |
| out_valid | output | 1 | `out_data` holds a delivered entry |
| out_data | output | 32 | Delivered entry |
| fill_level | output | ADDR_W+1 | Stored entries, core domain |
| running | output | 1 | Buffer centred, reads served |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |

## Verification
The bench builds three copies of the block: one with IN_W set to 8, one with 16 and one with 32. All three use ADDR_W=3, so the buffer holds eight entries. All three receive the same 32-bit word stream, cut into lanes in each copy's own width. A single expected-entry queue therefore checks all three packing orders. The small depth makes a run of twelve words enough to fill the buffer and overflow it. It also lets the half-depth threshold be approached one entry at a time. A drained buffer reaches underflow within a few reads.

// File: rtl/rxeb_pkg.sv
package rxeb_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DRAIN = 2'd3
    } rd_state_e;

endpackage

// File: rtl/rxeb_sync.sv
module rxeb_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/rxeb_packer.sv
module rxeb_packer
    import rxeb_pkg::*;
#(
    parameter int unsigned IN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_data,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);

    localparam int unsigned LANES = WORD_W / IN_W;
    localparam int unsigned CNT_W = (LANES > 1) ? $clog2(LANES) : 1;

    generate
        if (LANES == 1) begin : g_pass
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_valid <= 1'b0;
                    word       <= '0;
                end else if (clr) begin
                    word_valid <= 1'b0;
                end else begin
                    word_valid <= in_valid;
                    if (in_valid) begin
                        word <= WORD_W'(in_data);
                    end
                end
            end
        end else begin : g_pack
            logic [CNT_W-1:0]  lane;
            logic [WORD_W-1:0] acc;
            logic [WORD_W-1:0] merged;

            // earliest lane lands in the least significant bits
            always_comb begin
                merged = acc;
                merged[int'(lane) * IN_W +: IN_W] = in_data;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lane       <= '0;
                    acc        <= '0;
                    word_valid <= 1'b0;
                    word       <= '0;
                end else if (clr) begin
                    lane       <= '0;
                    word_valid <= 1'b0;
                end else begin
                    word_valid <= 1'b0;
                    if (in_valid) begin
                        acc <= merged;
                        if (lane == CNT_W'(LANES - 1)) begin
                            lane       <= '0;
                            word       <= merged;
                            word_valid <= 1'b1;
                        end else begin
                            lane <= lane + 1'b1;
                        end
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rxeb_ram.sv
module rxeb_ram
    import rxeb_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/rxeb_rd_ctrl.sv
module rxeb_rd_ctrl
    import rxeb_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              resync,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic              ack_s,
    output logic              flush_req,
    output logic [ADDR_W:0]   rgray,
    output logic [ADDR_W-1:0] raddr,
    output logic              re,
    output logic              running,
    output logic              out_valid,
    output logic [ADDR_W:0]   fill_level,
    output logic              unf_flag
);

    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned HALF  = DEPTH / 2;

    rd_state_e st, st_n;

    logic [ADDR_W:0] wbin_s;
    logic [ADDR_W:0] rbin;
    logic [ADDR_W:0] rbin_n;
    logic [ADDR_W:0] level;
    logic            empty;

    // gray to binary on the synchronized write pointer
    assign wbin_s[ADDR_W] = wgray_s[ADDR_W];
    generate
        for (genvar i = ADDR_W - 1; i >= 0; i--) begin : g_g2b
            assign wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
        end
    endgenerate

    assign level   = wbin_s - rbin;
    assign empty   = (rgray == wgray_s);
    assign re      = (st == ST_RUN) && rd_en && !empty;
    assign raddr   = rbin[ADDR_W-1:0];
    assign running = (st == ST_RUN);
    assign rbin_n  = rbin + 1'b1;

    // next-state selection
    always_comb begin
        st_n = st;
        unique case (st)
            ST_FILL: begin
                if (resync) begin
                    st_n = ST_FLUSH;
                end else if (level >= (ADDR_W+1)'(HALF)) begin
                    st_n = ST_RUN;
                end
            end
            ST_RUN: begin
                if (resync) begin
                    st_n = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (ack_s) begin
                    st_n = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (!ack_s) begin
                    st_n = ST_FILL;
                end
            end
            default: st_n = ST_FILL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_FILL;
        end else begin
            st <= st_n;
        end
    end

    // registered outputs and read pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin       <= '0;
            rgray      <= '0;
            out_valid  <= 1'b0;
            unf_flag   <= 1'b0;
            fill_level <= '0;
            flush_req  <= 1'b0;
        end else begin
            flush_req  <= (st_n == ST_FLUSH);
            fill_level <= level;
            out_valid  <= re;
            unique case (st)
                ST_FLUSH: begin
                    rbin     <= '0;
                    rgray    <= '0;
                    unf_flag <= 1'b0;
                end
                ST_RUN: begin
                    if (re) begin
                        rbin  <= rbin_n;
                        rgray <= rbin_n ^ (rbin_n >> 1);
                    end else if (rd_en && empty) begin
                        unf_flag <= 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf
    import rxeb_pkg::*;
#(
    parameter int unsigned IN_W   = 8,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              rx_valid,
    input  logic [IN_W-1:0]   rx_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              resync,
    input  logic              rd_en,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic [ADDR_W:0]   fill_level,
    output logic              running,
    output logic              ovf_flag,
    output logic              unf_flag
);

    logic              flush_req;
    logic              flush_w;
    logic [ADDR_W:0]   rgray;
    logic [ADDR_W:0]   rgray_w;
    logic [ADDR_W:0]   wbin;
    logic [ADDR_W:0]   wbin_n;
    logic [ADDR_W:0]   wgray;
    logic [ADDR_W:0]   wgray_r;
    logic              ack_w;
    logic              ack_r;
    logic              ovf_w;
    logic              full;
    logic              pk_valid;
    logic [WORD_W-1:0] pk_word;
    logic              we;
    logic              re;
    logic [ADDR_W-1:0] raddr;

    // ---------------- write domain ----------------
    rxeb_sync #(.W(1)) u_flush_sync (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (flush_req),
        .q     (flush_w)
    );

    rxeb_sync #(.W(ADDR_W+1)) u_rptr_sync (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rgray),
        .q     (rgray_w)
    );

    rxeb_packer #(.IN_W(IN_W)) u_pack (
        .clk        (wr_clk),
        .rst_n      (wr_rst_n),
        .clr        (flush_w),
        .in_valid   (rx_valid & ~flush_w),
        .in_data    (rx_data),
        .word_valid (pk_valid),
        .word       (pk_word)
    );

    assign full   = (wgray == {~rgray_w[ADDR_W:ADDR_W-1], rgray_w[ADDR_W-2:0]});
    assign we     = pk_valid && !full && !flush_w;
    assign wbin_n = wbin + 1'b1;

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            ack_w <= 1'b0;
            ovf_w <= 1'b0;
        end else if (flush_w) begin
            wbin  <= '0;
            wgray <= '0;
            ack_w <= 1'b1;
            ovf_w <= 1'b0;
        end else begin
            ack_w <= 1'b0;
            if (we) begin
                wbin  <= wbin_n;
                wgray <= wbin_n ^ (wbin_n >> 1);
            end else if (pk_valid) begin
                ovf_w <= 1'b1;
            end
        end
    end

    // ---------------- read domain ----------------
    rxeb_sync #(.W(ADDR_W+1)) u_wptr_sync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wgray),
        .q     (wgray_r)
    );

    rxeb_sync #(.W(1)) u_ack_sync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (ack_w),
        .q     (ack_r)
    );

    rxeb_sync #(.W(1)) u_ovf_sync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (ovf_w),
        .q     (ovf_flag)
    );

    rxeb_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
        .clk        (rd_clk),
        .rst_n      (rd_rst_n),
        .resync     (resync),
        .rd_en      (rd_en),
        .wgray_s    (wgray_r),
        .ack_s      (ack_r),
        .flush_req  (flush_req),
        .rgray      (rgray),
        .raddr      (raddr),
        .re         (re),
        .running    (running),
        .out_valid  (out_valid),
        .fill_level (fill_level),
        .unf_flag   (unf_flag)
    );

    rxeb_ram #(.ADDR_W(ADDR_W)) u_ram (
        .wr_clk   (wr_clk),
        .we       (we),
        .waddr    (wbin[ADDR_W-1:0]),
        .wdata    (pk_word),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .re       (re),
        .raddr    (raddr),
        .rdata    (out_data)
    );

endmodule

// File: rtl/rxeb_checker.sv
module rxeb_checker #(
    parameter int unsigned ADDR_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            resync,
    input logic            rd_en,
    input logic            running,
    input logic            out_valid,
    input logic [ADDR_W:0] fill_level,
    input logic            ovf_flag,
    input logic            unf_flag
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= (ADDR_W+1)'(DEPTH));

    assert_valid_after_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(running));

    assert_unf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unf_flag) |-> $past(rd_en && running));

    assert_resync_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resync && running) |=> !running);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_flag) |-> $past(!running));

endmodule

bind rx_elastic_buf rxeb_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (rd_clk),
    .rst_n      (rd_rst_n),
    .resync     (resync),
    .rd_en      (rd_en),
    .running    (running),
    .out_valid  (out_valid),
    .fill_level (fill_level),
    .ovf_flag   (ovf_flag),
    .unf_flag   (unf_flag)
);

// File: tb/rx_elastic_buf_tb.sv
`timescale 1ns/1ps
module rx_elastic_buf_tb;

    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;

    logic wr_clk = 1'b0;
    logic rd_clk = 1'b0;
    logic wr_rst_n = 1'b0;
    logic rd_rst_n = 1'b0;
    logic resync = 1'b0;
    logic rd_en = 1'b0;

    logic [31:0] din [3];
    logic        dv  [3];
    logic        ov  [3];
    logic [31:0] od  [3];
    logic [AW:0] fl  [3];
    logic        run [3];
    logic        ovf [3];
    logic        unf [3];

    always #4 rd_clk = ~rd_clk;   // 125 MHz core clock
    always #3 wr_clk = ~wr_clk;

    generate
        for (genvar k = 0; k < 3; k++) begin : g_dut
            localparam int W = 8 << k;
            rx_elastic_buf #(.IN_W(W), .ADDR_W(AW)) u_dut (
                .wr_clk     (wr_clk),
                .wr_rst_n   (wr_rst_n),
                .rx_valid   (dv[k]),
                .rx_data    (din[k][W-1:0]),
                .rd_clk     (rd_clk),
                .rd_rst_n   (rd_rst_n),
                .resync     (resync),
                .rd_en      (rd_en),
                .out_valid  (ov[k]),
                .out_data   (od[k]),
                .fill_level (fl[k]),
                .running    (run[k]),
                .ovf_flag   (ovf[k]),
                .unf_flag   (unf[k])
            );
        end
    endgenerate

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] exp_words [$];
    int rdidx  [3];
    int outcnt [3];

    function automatic string ptag(int k);
        return (k == 0) ? "R1" : (k == 1) ? "R2" : "R3";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // reference comparison on every core clock
    always @(negedge rd_clk) begin
        for (int k = 0; k < 3; k++) begin
            if (rd_rst_n && ov[k]) begin
                outcnt[k]++;
                if (rdidx[k] >= exp_words.size()) begin
                    checks++;
                    errors++;
                    $display("FAIL R5/R8 actual=unexpected output %h expected=no output (dut %0d)", od[k], k);
                end else begin
                    chk(ptag(k), od[k], exp_words[rdidx[k]]);
                    rdidx[k]++;
                end
            end
        end
    end

    task automatic wr_idle();
        @(negedge wr_clk);
        for (int k = 0; k < 3; k++) dv[k] = 1'b0;
    endtask

    task automatic push_word(logic [31:0] w);
        for (int c = 0; c < 4; c++) begin
            @(negedge wr_clk);
            din[0] = {24'h0, w[c*8 +: 8]};
            dv[0]  = 1'b1;
            din[1] = {16'h0, w[(c/2)*16 +: 16]};
            dv[1]  = (c % 2 == 0);
            din[2] = w;
            dv[2]  = (c == 0);
        end
        wr_idle();
        if ((exp_words.size() - rdidx[0]) < DEPTH) exp_words.push_back(w);
    endtask

    task automatic push_partial(logic [31:0] w);
        for (int c = 0; c < 2; c++) begin
            @(negedge wr_clk);
            din[0] = {24'h0, w[c*8 +: 8]};
            dv[0]  = 1'b1;
            din[1] = {16'h0, w[15:0]};
            dv[1]  = (c == 0);
            dv[2]  = 1'b0;
        end
        wr_idle();
    endtask

    task automatic rd_wait(int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic read_n(int n);
        repeat (n) begin
            @(negedge rd_clk);
            rd_en = 1'b1;
        end
        @(negedge rd_clk);
        rd_en = 1'b0;
        rd_wait(4);
    endtask

    task automatic do_resync();
        @(negedge rd_clk);
        resync = 1'b1;
        @(negedge rd_clk);
        resync = 1'b0;
        exp_words.delete();
        for (int k = 0; k < 3; k++) rdidx[k] = 0;
        rd_wait(40);
    endtask

    task automatic chk_status(string tag, int k, int f, bit r, bit o, bit u);
        chk({tag, " fill"}, 32'(fl[k]), 32'(f));
        chk({tag, " running"}, 32'(run[k]), 32'(r));
        chk({tag, " ovf"}, 32'(ovf[k]), 32'(o));
        chk({tag, " unf"}, 32'(unf[k]), 32'(u));
    endtask

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        int snap [3];
        for (int k = 0; k < 3; k++) begin
            din[k] = '0; dv[k] = 1'b0; rdidx[k] = 0; outcnt[k] = 0;
        end
        rd_wait(5);
        // R10: reset state
        for (int k = 0; k < 3; k++) begin
            chk_status("R10", k, 0, 0, 0, 0);
            chk("R10 out_valid", 32'(ov[k]), 32'd0);
        end
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        rd_wait(5);

        // R4: below half depth, reads are held off
        push_word(32'h33221100);
        push_word(32'h77665544);
        push_word(32'hBBAA9988);
        rd_wait(20);
        for (int k = 0; k < 3; k++) snap[k] = outcnt[k];
        read_n(3);
        for (int k = 0; k < 3; k++) begin
            chk_status("R4 below half", k, 3, 0, 0, 0);
            chk("R4 no output", 32'(outcnt[k]), 32'(snap[k]));
        end

        // R4/R6: reaching half depth starts running
        push_word(32'hFFEEDDCC);
        rd_wait(20);
        for (int k = 0; k < 3; k++) chk_status("R4 half", k, 4, 1, 0, 0);

        // R1/R2/R3/R5: drain in order, then R8 underflow
        read_n(6);
        for (int k = 0; k < 3; k++) begin
            chk("R5 count", 32'(outcnt[k]), 32'(snap[k] + 4));
            chk_status("R8 underflow", k, 0, 1, 0, 1);
        end

        // R9: resync clears flags and returns to fill
        do_resync();
        for (int k = 0; k < 3; k++) chk_status("R9 cleared", k, 0, 0, 0, 0);

        // R9: partial entry discarded across resync
        push_partial(32'hDEADBEEF);
        do_resync();
        for (int i = 0; i < 4; i++) push_word(32'h10203040 + 32'(i) * 32'h01010101);
        rd_wait(20);
        for (int k = 0; k < 3; k++) chk_status("R9 refill", k, 4, 1, 0, 0);
        read_n(4);
        for (int k = 0; k < 3; k++) chk("R9 delivered", 32'(rdidx[k]), 32'd4);

        // R7/R6: overflow keeps the first DEPTH entries
        do_resync();
        for (int i = 0; i < 12; i++) push_word(32'hC0000000 + 32'(i) * 32'h00110011);
        rd_wait(20);
        for (int k = 0; k < 3; k++) chk_status("R7 overflow", k, DEPTH, 1, 1, 0);
        read_n(DEPTH);
        for (int k = 0; k < 3; k++) begin
            chk("R7 kept", 32'(rdidx[k]), 32'(DEPTH));
            chk_status("R7 sticky", k, 0, 1, 1, 0);
        end

        // R9: resync clears the overflow flag
        do_resync();
        for (int k = 0; k < 3; k++) chk_status("R9 ovf clear", k, 0, 0, 0, 0);

        summary();
    end

endmodule